// File: doc/BRIEF.md
# PCI Power-Management Capability Controller

This block holds the power-management capability of one PCI function. A configuration port reads two dwords. The first is a read-only capability dword that tells the host which power states and wake features are supported. The second is a control/status dword. Through it the host moves the function between D0 and D3hot, arms wake signalling, and acknowledges a pending wake.

A single-cycle `wake_evt` pulse stands for a wake request from elsewhere in the chip. When wake signalling is armed, the pulse latches a sticky wake flag. While the flag and the arm bit are both set, the active-low `pme_n` line is driven low. The auxiliary-power detect input `aux_det` does two things. It changes the advertised D3cold wake bit and the auxiliary-current field. It also decides whether the wake flag survives a PCI reset.

Top module: `pmcap_ctrl`

Resets:
- `por_n` is an asynchronous power-on reset that clears everything.
- `pci_rst_n` is a PCI reset, sampled on the clock.

Reads are combinational from `cfg_addr`. Writes take effect at the rising edge where `cfg_wr` is high.

## Requirements
- R1: At offset 78h the capability dword reads as follows:
  - bit 30 (wake from D3hot) = 1 and bit 27 (wake from D0) = 1;
  - bits 29, 28 (wake from D2/D1) = 0 and bits 26, 25 (D2/D1 supported) = 0;
  - bits 21, 20 and 19 = 0;
  - bits 18:16 (version) = 010b;
  - bits 15:8 (next pointer) = 00h;
  - bits 7:0 (capability ID) = 01h.
- R2: Capability bit 31 (wake from D3cold) equals `aux_det`. Bits 24:22 (auxiliary current) read 000b when `aux_det` is 0 and 110b when it is 1.
- R3: At offset 7Ch the control/status dword reads as follows: bits 1:0 hold the power state (00b = D0, 11b = D3hot), bit 8 holds the wake-arm bit, and bit 15 holds the wake flag. All other bits read 0. Any other offset reads 0.
- R4: A write of 00b or 11b to bits 1:0 at 7Ch sets the power state. A write of 01b or 10b leaves the previous state unchanged.
- R5: After power-on reset the control/status dword reads 0 and `pme_n` is 1, whatever the value of `aux_det`.
- R6: A `wake_evt` pulse while the wake-arm bit is 1 sets the wake flag at the next edge. With the arm bit at 0, the pulse leaves the flag unchanged.
- R7: Writing 1 to bit 15 at 7Ch clears the wake flag, and writing 0 there leaves it unchanged. When a wake and a clearing write fall in the same cycle, the wake wins and the flag ends set. The wake is qualified by the arm bit held before that cycle.
- R8: `pme_n` is 0 exactly while the wake flag and the wake-arm bit are both 1, and 1 otherwise.
- R9: A PCI reset with `aux_det` at 0 clears the power state, the wake-arm bit and the wake flag.
- R10: A PCI reset with `aux_det` at 1 keeps the wake flag and clears the power state and the wake-arm bit. Only power-on reset then clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pci_rst_n | input | 1 | PCI reset, active low, sampled on clk |
| aux_det | input | 1 | Auxiliary power present |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| wake_evt | input | 1 | Single-cycle wake request |
| pwr_state | output | 2 | Current power state |
| pme_n | output | 1 | Wake signal, active low |

## Verification
Two functions can meet in one cycle: a wake pulse that sets the flag, and a host write that clears it. The bench drives every combination of prior flag, arm bit, wake pulse and clear bit in one cycle. It then reads the flag and `pme_n` back and compares them with the result of "wake wins over clear". The second overlap is a PCI reset that meets a held wake flag. The bench runs it with the auxiliary detect input both low and high and checks whether the flag survived.

// File: rtl/pmcap_pkg.sv
package pmcap_pkg;
   localparam logic [1:0] PS_D0  = 2'b00;
   localparam logic [1:0] PS_D3  = 2'b11;
   localparam int STATE_LSB      = 0;
   localparam int ARM_BIT        = 8;
   localparam int FLAG_BIT       = 15;
   localparam logic [7:0] CAP_ID = 8'h01;
   localparam logic [2:0] CAP_VER = 3'b010;

   function automatic logic ps_legal(input logic [1:0] v);
      return (v == PS_D0) || (v == PS_D3);
   endfunction
endpackage

// File: rtl/pmcap_capword.sv
module pmcap_capword
   import pmcap_pkg::*;
#(
   parameter logic [2:0] AUX_CODE = 3'b110,
   parameter logic [7:0] NEXT_PTR = 8'h00
) (
   input  logic        aux_det,
   output logic [31:0] cap_word
);
   localparam logic [4:0] WAKE_FROM = 5'b01001; // D3cold(slot),D3hot,D2,D1,D0
   always_comb begin
      cap_word        = '0;
      cap_word[31:27] = WAKE_FROM;
      cap_word[31]    = aux_det;
      cap_word[26:25] = 2'b00;
      cap_word[24:22] = aux_det ? AUX_CODE : 3'b000;
      cap_word[18:16] = CAP_VER;
      cap_word[15:8]  = NEXT_PTR;
      cap_word[7:0]   = CAP_ID;
   end
endmodule

// File: rtl/pmcap_state.sv
module pmcap_state
   import pmcap_pkg::*;
(
   input  logic        clk,
   input  logic        por_n,
   input  logic        pci_rst_n,
   input  logic        csr_wr,
   input  logic [31:0] wdata,
   output logic [1:0]  state_q,
   output logic        arm_q
);
   logic [1:0] wr_state;
   assign wr_state = wdata[STATE_LSB +: 2];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= PS_D0;
         arm_q   <= 1'b0;
      end else if (!pci_rst_n) begin
         state_q <= PS_D0;
         arm_q   <= 1'b0;
      end else if (csr_wr) begin
         if (ps_legal(wr_state))
            state_q <= wr_state;
         arm_q <= wdata[ARM_BIT];
      end
   end
endmodule

// File: rtl/pmcap_pme.sv
module pmcap_pme #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic pci_rst_n,
   input  logic aux_det,
   input  logic wake_evt,
   input  logic arm_q,
   input  logic clr_req,
   output logic flag_q,
   output logic pme_n
);
   logic set_req;
   assign set_req = wake_evt & arm_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         flag_q <= 1'b0;
      else if (!pci_rst_n) begin
         if (!aux_det)
            flag_q <= 1'b0;
      end else if (set_req)
         flag_q <= 1'b1;
      else if (clr_req)
         flag_q <= 1'b0;
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic pme_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) pme_q <= 1'b1;
            else        pme_q <= ~(flag_q & arm_q);
         end
         assign pme_n = pme_q;
      end else begin : g_comb_out
         assign pme_n = ~(flag_q & arm_q);
      end
   endgenerate
endmodule

// File: rtl/pmcap_ctrl.sv
module pmcap_ctrl
   import pmcap_pkg::*;
#(
   parameter int                 ADDR_W      = 8,
   parameter logic [ADDR_W-1:0]  CAP_OFS     = 8'h78,
   parameter logic [ADDR_W-1:0]  CSR_OFS     = 8'h7C,
   parameter logic [2:0]         AUX_CODE    = 3'b110,
   parameter logic [7:0]         NEXT_PTR    = 8'h00,
   parameter bit                 REG_PME_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pci_rst_n,
   input  logic              aux_det,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              wake_evt,
   output logic [1:0]        pwr_state,
   output logic              pme_n
);
   generate
      if (CAP_OFS[1:0] != 2'b00 || CSR_OFS[1:0] != 2'b00) begin : g_bad_align
         $error("capability offsets must be dword aligned");
      end
      if (CAP_OFS == CSR_OFS) begin : g_bad_overlap
         $error("capability and control offsets must differ");
      end
   endgenerate

   logic        hit_cap, hit_csr, csr_wr;
   logic [31:0] cap_word, csr_word;
   logic [1:0]  state_q;
   logic        arm_q, flag_q;

   assign hit_cap = (cfg_addr == CAP_OFS);
   assign hit_csr = (cfg_addr == CSR_OFS);
   assign csr_wr  = cfg_wr & hit_csr;

   pmcap_capword #(.AUX_CODE(AUX_CODE), .NEXT_PTR(NEXT_PTR)) u_cap (
      .aux_det  (aux_det),
      .cap_word (cap_word)
   );

   pmcap_state u_state (
      .clk       (clk),
      .por_n     (por_n),
      .pci_rst_n (pci_rst_n),
      .csr_wr    (csr_wr),
      .wdata     (cfg_wdata),
      .state_q   (state_q),
      .arm_q     (arm_q)
   );

   pmcap_pme #(.REG_OUT(REG_PME_OUT)) u_pme (
      .clk       (clk),
      .por_n     (por_n),
      .pci_rst_n (pci_rst_n),
      .aux_det   (aux_det),
      .wake_evt  (wake_evt),
      .arm_q     (arm_q),
      .clr_req   (csr_wr & cfg_wdata[FLAG_BIT]),
      .flag_q    (flag_q),
      .pme_n     (pme_n)
   );

   always_comb begin
      csr_word                   = '0;
      csr_word[STATE_LSB +: 2]   = state_q;
      csr_word[ARM_BIT]          = arm_q;
      csr_word[FLAG_BIT]         = flag_q;
   end

   assign cfg_rdata = hit_cap ? cap_word : (hit_csr ? csr_word : 32'h0);
   assign pwr_state = state_q;
endmodule

// File: rtl/pmcap_ctrl_chk.sv
module pmcap_ctrl_chk
   import pmcap_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] CAP_OFS     = 8'h78,
   parameter logic [ADDR_W-1:0] CSR_OFS     = 8'h7C,
   parameter bit                REG_PME_OUT = 1'b0
) (
   input logic              clk,
   input logic              por_n,
   input logic              pci_rst_n,
   input logic              aux_det,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              cfg_wr,
   input logic [31:0]       cfg_wdata,
   input logic [31:0]       cfg_rdata,
   input logic              wake_evt,
   input logic [1:0]        pwr_state,
   input logic              arm_q,
   input logic              flag_q,
   input logic              pme_n
);
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
      ps_legal(pwr_state)); // R4
   AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
      (pci_rst_n && cfg_wr && cfg_addr == CSR_OFS && !ps_legal(cfg_wdata[1:0]))
      |=> $stable(pwr_state)); // R4
   AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!por_n)
      (pci_rst_n && wake_evt && arm_q) |=> flag_q); // R6
   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
      (pci_rst_n && cfg_wr && cfg_addr == CSR_OFS && !cfg_wdata[15] && flag_q)
      |=> flag_q); // R7
   AST_PCIRST_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
      (!pci_rst_n && !aux_det) |=> (!flag_q && !arm_q && pwr_state == PS_D0)); // R9
   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!por_n)
      (!pci_rst_n && aux_det && flag_q) |=> flag_q); // R10
   AST_PME_DRIVE: assert property (@(posedge clk) disable iff (!por_n)
      (!REG_PME_OUT && flag_q && arm_q) |-> !pme_n); // R8
   AST_AUX_BIT: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_addr == CAP_OFS) |-> (cfg_rdata[31] == aux_det)); // R2
endmodule

bind pmcap_ctrl pmcap_ctrl_chk #(
   .ADDR_W(ADDR_W), .CAP_OFS(CAP_OFS), .CSR_OFS(CSR_OFS), .REG_PME_OUT(REG_PME_OUT)
) u_chk (
   .clk(clk), .por_n(por_n), .pci_rst_n(pci_rst_n), .aux_det(aux_det),
   .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
   .wake_evt(wake_evt), .pwr_state(pwr_state), .arm_q(arm_q), .flag_q(flag_q),
   .pme_n(pme_n)
);

// File: tb/pmcap_ctrl_tb.sv
module pmcap_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] CAP = 8'h78;
   localparam logic [7:0] CSR = 8'h7C;

   logic        clk = 1'b0;
   logic        por_n, pci_rst_n, aux_det, cfg_wr, wake_evt, pme_n;
   logic [7:0]  cfg_addr;
   logic [31:0] cfg_wdata, cfg_rdata, rd;
   logic [1:0]  pwr_state;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmcap_ctrl u_dut (
      .clk(clk), .por_n(por_n), .pci_rst_n(pci_rst_n), .aux_det(aux_det),
      .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .wake_evt(wake_evt), .pwr_state(pwr_state),
      .pme_n(pme_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rdw(input logic [7:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic pulse_wake();
      wake_evt = 1'b1;
      @(negedge clk);
      wake_evt = 1'b0;
   endtask

   function automatic logic [31:0] csrv(input logic [1:0] s, input logic en, input logic f);
      return {16'h0, f, 6'h0, en, 6'h0, s};
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] capx, fixm;
      por_n = 0; pci_rst_n = 1; aux_det = 0; cfg_wr = 0; wake_evt = 0;
      cfg_addr = 8'h00; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      por_n = 1;
      @(negedge clk);
      // R5 reset state
      rdw(CSR, rd); chk("R5 csr", rd, 32'h0);
      chk("R5 pme_n", {31'h0, pme_n}, 32'h1);

      // R1/R2 capability word for both aux values
      fixm = 32'h7E3F_FFFF & ~32'h01C0_0000;
      for (int a = 0; a < 2; a++) begin
         aux_det = a[0];
         capx = {a[0], 1'b1, 2'b00, 1'b1, 2'b00, (a[0] ? 3'b110 : 3'b000),
                 3'b000, 3'b010, 8'h00, 8'h01};
         rdw(CAP, rd);
         chk("R1 fixed fields", rd & fixm, capx & fixm);
         chk("R2 aux fields", rd & 32'h81C0_0000, capx & 32'h81C0_0000);
      end
      aux_det = 0;

      // R3 other offsets
      rdw(8'h00, rd); chk("R3 offset 00", rd, 32'h0);
      rdw(8'h7D, rd); chk("R3 offset 7D", rd, 32'h0);
      rdw(8'hFC, rd); chk("R3 offset FC", rd, 32'h0);

      // R4 power-state sweep
      for (int f = 0; f < 2; f++) begin
         for (int v = 0; v < 4; v++) begin
            logic [1:0] from, exps;
            from = f[0] ? 2'b11 : 2'b00;
            wr(CSR, {30'h0, from});
            wr(CSR, {30'h0, v[1:0]});
            exps = (v == 0 || v == 3) ? v[1:0] : from;
            rdw(CSR, rd); chk("R4 state write", rd, csrv(exps, 1'b0, 1'b0));
            chk("R4 pwr_state", {30'h0, pwr_state}, {30'h0, exps});
         end
      end

      // R6/R7/R8 wake vs clear sweep
      for (int s = 0; s < 2; s++)
         for (int en = 0; en < 2; en++)
            for (int wk = 0; wk < 2; wk++)
               for (int cl = 0; cl < 2; cl++) begin
                  logic expf;
                  wr(CSR, csrv(2'b00, 1'b1, 1'b1));
                  if (s == 1) pulse_wake();
                  wr(CSR, csrv(2'b00, en[0], 1'b0));
                  wake_evt = wk[0];
                  wr(CSR, csrv(2'b00, en[0], cl[0]));
                  wake_evt = 1'b0;
                  expf = (wk[0] & en[0]) | (s[0] & ~cl[0]);
                  rdw(CSR, rd);
                  if (wk == 1 && cl == 1)
                     chk("R7 wake beats clear", rd, csrv(2'b00, en[0], expf));
                  else if (wk == 1)
                     chk("R6 wake gating", rd, csrv(2'b00, en[0], expf));
                  else
                     chk("R7 clear/zero write", rd, csrv(2'b00, en[0], expf));
                  chk("R8 pme_n", {31'h0, pme_n}, {31'h0, ~(expf & en[0])});
               end

      // R9/R10 PCI reset against a held flag
      for (int a = 0; a < 2; a++) begin
         aux_det = a[0];
         wr(CSR, csrv(2'b11, 1'b1, 1'b1));
         pulse_wake();
         chk("R8 pme_n asserted", {31'h0, pme_n}, 32'h0);
         pci_rst_n = 0;
         @(negedge clk);
         pci_rst_n = 1;
         rdw(CSR, rd);
         if (a == 0) chk("R9 pci reset clears", rd, 32'h0);
         else        chk("R10 flag kept", rd, csrv(2'b00, 1'b0, 1'b1));
         chk("R8 pme_n after pci reset", {31'h0, pme_n}, 32'h1);
      end

      // R5 power-on reset clears sticky flag
      por_n = 0;
      @(negedge clk);
      por_n = 1;
      rdw(CSR, rd); chk("R5 por clears sticky", rd, 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule